// File: doc/BRIEF.md
# Internal Data Space Access Router

This block sits between a processor core's internal data-memory access port and the two storage targets that answer it: a 256-byte scratch RAM and a bus of special-function registers (SFRs). The core presents an 8-bit address, a flag that says whether the access uses indirect addressing, a read strobe, a write strobe and write data. The router decides which target gets the access, raises that target's enable and forwards the address and data. It also steers the answering target's read data back to the core.

The bottom half of the address space, 0x00 to 0x7F, is plain RAM for both addressing modes. The top half, 0x80 to 0xFF, is shared by two separate stores. An indirect access in that window reaches the upper RAM bytes. A direct access in that window reaches the SFR bus. The address alone never picks between them; the mode flag does.

Both targets are synchronous: each registers its read data on the edge that samples its read enable. The router returns that data to the core one clock after the read request. A parameter mask lists which SFR offsets exist. Accesses to SFR slots outside the mask never reach the bus.

Top module: `idm_router`

## Requirements
- R1: After reset, and before any read completes, `rd_data` is 0x00. While neither `acc_rd` nor `acc_wr` is high, all four target enables (`ram_re`, `ram_we`, `sfr_re`, `sfr_we`) are low.
- R2: An access to an address in 0x00–0x7F goes to the RAM at the same address, whatever the value of `acc_ind`.
- R3: An access with `acc_ind` = 1 to an address in 0x80–0xFF goes to the RAM at the same address and never enables the SFR bus.
- R4: An access with `acc_ind` = 0 to an address in 0x80–0xFF goes to the SFR bus, with `sfr_addr` equal to the access address, and never enables the RAM. A write there leaves the RAM contents unchanged.
- R5: The data of a read shows on `rd_data` one clock after the cycle in which `acc_rd` is high. It comes from the target selected in the request cycle.
- R6: At most one of the four target enables is high in any cycle. A write raises exactly one write enable, with the write data forwarded unchanged, except in the case covered by R7.
- R7: An SFR slot is implemented when bit (address − 0x80) of the mask parameter is set. By default these are the addresses whose low three bits are zero (0x80, 0x88, …, 0xF8). A direct read of any other address in 0x80–0xFF returns 0x00. A direct write to such an address raises no enable.
- R8: When `acc_rd` and `acc_wr` are both high, only the write is carried out. No read enable rises, and in the next cycle `rd_data` keeps the value it had.
- R9: In a cycle after which no read was requested, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 8 | Internal data address |
| acc_ind | input | 1 | 1 = indirect addressing, 0 = direct |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_wdata | input | 8 | Write data |
| ram_addr | output | 8 | RAM address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, registered by the RAM |
| sfr_addr | output | 8 | SFR bus address |
| sfr_re | output | 1 | SFR read enable |
| sfr_we | output | 1 | SFR write enable |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, registered by the SFR bus |
| rd_data | output | 8 | Read data returned to the core |

## Verification
The hardest case to show from the ports is that the two stores behind 0x80–0xFF are truly separate. A routing error can hide when a write and a later read take the same wrong path. The stimulus therefore fills every RAM byte indirectly with one pattern. It then writes a different pattern to the whole upper window directly, and overwrites the lower half directly with a third pattern. Full sweeps read every address back in both modes, so any cross-over shows up as the wrong pattern. A read-then-collision sequence with a known earlier value shows that the returned data holds.

// File: rtl/idm_pkg.sv
package idm_pkg;

  // Source of the data returned for a read request
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_SFR  = 2'd2
  } idm_src_e;

endpackage

// File: rtl/idm_sfr_map.sv
module idm_sfr_map #(
  parameter int          AW       = 8,
  parameter logic [(1<<(AW-1))-1:0] SFR_IMPL = {((1<<(AW-1))/8){8'h01}}
) (
  input  logic [AW-2:0] offset,
  output logic          present
);

  localparam int SLOTS = 1 << (AW - 1);

  logic [SLOTS-1:0] hit;

  // One decoded slot per possible SFR offset, gated by the mask
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hit[s] = SFR_IMPL[s] && (offset == s[AW-2:0]);
  end

  assign present = |hit;

endmodule

// File: rtl/idm_route.sv
module idm_route
  import idm_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [(1<<(AW-1))-1:0] SFR_IMPL = {((1<<(AW-1))/8){8'h01}}
) (
  input  logic     [AW-1:0] addr,
  input  logic              ind,
  input  logic              rd,
  input  logic              wr,
  output logic              ram_re,
  output logic              ram_we,
  output logic              sfr_re,
  output logic              sfr_we,
  output logic              rd_go,
  output idm_src_e          rd_src
);

  logic upper;
  logic to_sfr;
  logic present;
  logic wr_go;

  idm_sfr_map #(
    .AW       (AW),
    .SFR_IMPL (SFR_IMPL)
  ) i_map (
    .offset  (addr[AW-2:0]),
    .present (present)
  );

  // Upper window + direct mode selects the SFR space; mode decides, not address
  assign upper  = addr[AW-1];
  assign to_sfr = upper && !ind;

  // Write has priority over a simultaneous read
  assign wr_go = wr;
  assign rd_go = rd && !wr;

  assign ram_we = wr_go && !to_sfr;
  assign ram_re = rd_go && !to_sfr;
  assign sfr_we = wr_go && to_sfr && present;
  assign sfr_re = rd_go && to_sfr && present;

  always_comb begin
    rd_src = SRC_NONE;
    if (rd_go) begin
      if (!to_sfr)      rd_src = SRC_RAM;
      else if (present) rd_src = SRC_SFR;
      else              rd_src = SRC_NONE;
    end
  end

endmodule

// File: rtl/idm_rdret.sv
module idm_rdret
  import idm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  idm_src_e      rd_src,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] sfr_rdata,
  output logic [DW-1:0] rd_data
);

  logic          valid_q;
  idm_src_e      src_q;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] picked;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      src_q   <= SRC_NONE;
      hold_q  <= '0;
    end else begin
      valid_q <= rd_go;
      src_q   <= rd_src;
      hold_q  <= rd_data;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM: picked = ram_rdata;
      SRC_SFR: picked = sfr_rdata;
      default: picked = '0;
    endcase
  end

  // Fresh target data in the cycle after a read; the last value otherwise
  assign rd_data = valid_q ? picked : hold_q;

endmodule

// File: rtl/idm_router.sv
module idm_router
  import idm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [(1<<(AW-1))-1:0] SFR_IMPL = {((1<<(AW-1))/8){8'h01}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_ind,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_wdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_re,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] sfr_addr,
  output logic          sfr_re,
  output logic          sfr_we,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  output logic [DW-1:0] rd_data
);

  logic     rd_go;
  idm_src_e rd_src;

  idm_route #(
    .AW       (AW),
    .SFR_IMPL (SFR_IMPL)
  ) i_route (
    .addr   (acc_addr),
    .ind    (acc_ind),
    .rd     (acc_rd),
    .wr     (acc_wr),
    .ram_re (ram_re),
    .ram_we (ram_we),
    .sfr_re (sfr_re),
    .sfr_we (sfr_we),
    .rd_go  (rd_go),
    .rd_src (rd_src)
  );

  idm_rdret #(
    .DW (DW)
  ) i_rdret (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (rd_go),
    .rd_src    (rd_src),
    .ram_rdata (ram_rdata),
    .sfr_rdata (sfr_rdata),
    .rd_data   (rd_data)
  );

  assign ram_addr  = acc_addr;
  assign ram_wdata = acc_wdata;
  assign sfr_addr  = acc_addr;
  assign sfr_wdata = acc_wdata;

  // R6: never two targets or two directions at once
  a_r6_single_enable: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_re, ram_we, sfr_re, sfr_we}));

  // R3: indirect accesses never touch the SFR bus
  a_r3_indirect_no_sfr: assert property (@(posedge clk) disable iff (rst)
    acc_ind |-> (!sfr_re && !sfr_we));

  // R4: direct upper-window accesses never touch the RAM
  a_r4_direct_upper_no_ram: assert property (@(posedge clk) disable iff (rst)
    (!acc_ind && acc_addr[AW-1]) |-> (!ram_re && !ram_we));

  // R5: RAM read data appears one clock after the RAM read enable
  a_r5_ram_return: assert property (@(posedge clk) disable iff (rst)
    ram_re |=> (rd_data == ram_rdata));

  // R5: SFR read data appears one clock after the SFR read enable
  a_r5_sfr_return: assert property (@(posedge clk) disable iff (rst)
    sfr_re |=> (rd_data == sfr_rdata));

  // R8: a collision keeps the returned data and starts no read
  a_r8_collision_hold: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_wr) |=> (rd_data == $past(rd_data)));

  a_r8_collision_no_read: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_wr) |-> (!ram_re && !sfr_re));

  // R7: a direct upper read that reaches no target returns zero
  a_r7_absent_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !acc_wr && !acc_ind && acc_addr[AW-1] && !sfr_re) |=> (rd_data == '0));

endmodule

// File: tb/test_idm_router.sv
module test_idm_router;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] acc_addr;
  logic       acc_ind, acc_rd, acc_wr;
  logic [7:0] acc_wdata;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;
  logic       ram_re, ram_we;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_re, sfr_we;
  logic [7:0] rd_data;

  int checks = 0;
  int bad    = 0;
  int stray_sfr = 0;
  bit done = 0;

  logic [7:0] ram_m [256];
  logic [7:0] sfr_m [128];

  always #5 clk = ~clk;

  idm_router i_idm_router (
    .clk(clk), .rst(rst),
    .acc_addr(acc_addr), .acc_ind(acc_ind), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata),
    .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .sfr_addr(sfr_addr), .sfr_re(sfr_re), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .rd_data(rd_data)
  );

  // Synchronous RAM target
  always_ff @(posedge clk) begin
    if (ram_we) ram_m[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= ram_m[ram_addr];
  end

  // SFR stub: register file over the upper window
  always_ff @(posedge clk) begin
    if (sfr_we) begin
      sfr_m[sfr_addr[6:0]] <= sfr_wdata;
      if (sfr_addr[2:0] != 3'd0 || !sfr_addr[7]) stray_sfr <= stray_sfr + 1;
    end
    if (sfr_re) sfr_rdata <= sfr_m[sfr_addr[6:0]];
  end

  function automatic logic [7:0] pat_ind(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction
  function automatic logic [7:0] pat_sfr(input logic [7:0] a);
    return a + 8'h33;
  endfunction
  function automatic logic [7:0] pat_low(input logic [7:0] a);
    return ~a;
  endfunction
  function automatic bit present(input logic [7:0] a);
    return a[7] && (a[2:0] == 3'd0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a write; check the enables and forwarded fields in the same cycle
  task automatic do_wr(input logic [7:0] a, input bit ind, input logic [7:0] d);
    bit to_sfr;
    @(negedge clk);
    acc_addr = a; acc_ind = ind; acc_wr = 1'b1; acc_rd = 1'b0; acc_wdata = d;
    #1;
    to_sfr = a[7] && !ind;
    if (!to_sfr) begin
      check("R2/R3 ram write route", {ram_we, sfr_we, ram_addr, ram_wdata}, {1'b1, 1'b0, a, d});
    end else if (present(a)) begin
      check("R4/R6 sfr write route", {ram_we, sfr_we, sfr_addr, sfr_wdata}, {1'b0, 1'b1, a, d});
    end else begin
      check("R7 absent sfr write", {ram_we, sfr_we}, 2'b00);
    end
  endtask

  // Drive a read for one cycle and check rd_data in the next cycle
  task automatic do_rd(input logic [7:0] a, input bit ind, input logic [7:0] exp, input string req);
    @(negedge clk);
    acc_addr = a; acc_ind = ind; acc_rd = 1'b1; acc_wr = 1'b0;
    @(negedge clk);
    acc_rd = 1'b0;
    check(req, rd_data, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_addr = '0; acc_ind = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset value and idle enables
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 idle enables", {ram_re, ram_we, sfr_re, sfr_we}, 4'b0000);

    // Fill the whole RAM indirectly
    for (int a = 0; a < 256; a++) do_wr(a[7:0], 1'b1, pat_ind(a[7:0]));
    // Direct writes over the upper window hit only SFRs (R4, R7)
    for (int a = 128; a < 256; a++) do_wr(a[7:0], 1'b0, pat_sfr(a[7:0]));
    // Direct writes to the lower half reach RAM (R2)
    for (int a = 0; a < 128; a++) do_wr(a[7:0], 1'b0, pat_low(a[7:0]));
    @(negedge clk);
    acc_wr = 1'b0;

    // Indirect read sweep: upper RAM untouched by direct writes (R3, R4, R5)
    for (int a = 0; a < 256; a++)
      do_rd(a[7:0], 1'b1, (a < 128) ? pat_low(a[7:0]) : pat_ind(a[7:0]), "R3/R5 indirect read");
    // Direct read sweep (R2, R4, R7)
    for (int a = 0; a < 256; a++) begin
      if (a < 128)             do_rd(a[7:0], 1'b0, pat_low(a[7:0]), "R2 direct low read");
      else if (present(a[7:0])) do_rd(a[7:0], 1'b0, pat_sfr(a[7:0]), "R4 direct sfr read");
      else                      do_rd(a[7:0], 1'b0, 8'h00, "R7 absent sfr read");
    end
    check("R7 no stray sfr writes", stray_sfr, 0);

    // R9: idle cycles keep the last returned value
    do_rd(8'h90, 1'b1, pat_ind(8'h90), "R5 read before hold");
    @(negedge clk);
    check("R9 hold after idle", rd_data, pat_ind(8'h90));
    check("R1 idle enables later", {ram_re, ram_we, sfr_re, sfr_we}, 4'b0000);

    // R8: collision, write wins and rd_data holds
    @(negedge clk);
    acc_addr = 8'h20; acc_ind = 1'b0; acc_rd = 1'b1; acc_wr = 1'b1; acc_wdata = 8'hC3;
    #1;
    check("R8 collision enables", {ram_re, ram_we, sfr_re, sfr_we}, 4'b0100);
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    check("R8 collision hold", rd_data, pat_ind(8'h90));
    do_rd(8'h20, 1'b1, 8'hC3, "R8 collision write landed");

    // R8 on the SFR side: direct collision at an implemented slot
    @(negedge clk);
    acc_addr = 8'hA8; acc_ind = 1'b0; acc_rd = 1'b1; acc_wr = 1'b1; acc_wdata = 8'h7E;
    #1;
    check("R8 sfr collision enables", {ram_re, ram_we, sfr_re, sfr_we}, 4'b0001);
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    check("R8 sfr collision hold", rd_data, 8'hC3);
    do_rd(8'hA8, 1'b0, 8'h7E, "R8 sfr write landed");
    do_rd(8'hA8, 1'b1, pat_ind(8'hA8), "R3 upper ram intact after sfr write");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule